// File: doc/BRIEF.md
# SDRAM Bank Configuration Register Unit

This unit is the programming side of an SDRAM controller. Software reaches its registers indirectly. An offset port selects a register, and a data port then reads or writes the selected register. The register set covers two error-status words, an error address, a global configuration word, a read-only status word, refresh timing, power management, a variable number of bank-configuration words, timing, ECC configuration and ECC error status. Each register has its own write mask and its own forced bits.

Each bank-configuration word is decoded into an address window for an external address decoder. The window is made of a base address, a size in bytes and a valid flag. A window counts as valid only while the global enable bit of the configuration word is set. The status word records when the controller is switched off and when the self-refresh request bit is switched on. An interrupt line stays high for as long as a nonzero ECC error status is held.

Top module: `sdram_cfg_regs`

## Requirements
- R1: After a synchronous active-low reset, the registers hold these values: offset 0, configuration 0x00800000, refresh 0x05F00000, timing 0x00854009, power management 0x07C00000. Every other register is zero, every window is invalid and the ECC interrupt is low.
- R2: Data-port reads and writes act on the register named by the offset register, which was loaded on an earlier clock edge. If the offset and the data are written in the same cycle, the data goes to the old offset. The offsets are: error status 0 at 0x00, error status 1 at 0x08, error address at 0x10, configuration at 0x20, status at 0x24, refresh at 0x30, power management at 0x34, bank n at 0x40+4n, timing at 0x80, ECC config at 0x94 and ECC error status at 0x98.
- R3: A bank word keeps only the bits in 0xFFDEE001. Its window base is the word's bits 31:23 followed by 23 zero bits. Its window size is 4 MiB shifted left by bits 19:17.
- R4: A window is valid exactly when bit 0 of its bank word and bit 31 of the configuration word are both set.
- R5: When configuration bit 31 goes from 0 to 1, status bit 31 is cleared. When it goes from 1 to 0, status bit 31 is set.
- R6: Status bit 30 is set when configuration bit 30 goes from 0 to 1 and cleared when it goes from 1 to 0. Writes to the status register have no effect.
- R7: Writing an error-status register clears the bits written as ones and never sets a bit.
- R8: Refresh keeps the bits in 0x3FF80000, timing keeps 0x018FC01F and ECC config keeps 0x00F00000. Power management keeps bits 31:27 and always reads bits 26:22 as ones.
- R9: The ECC interrupt is high exactly while the ECC error status is nonzero. It changes on the clock edge that stores the write.
- R10: Offsets that are not implemented read as zero, and writes to them change no register.
- R11: The configuration word, the error address and the ECC error status store all 32 written bits. The offset register reads back through its own port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ofs_we | input | 1 | Load the offset register |
| ofs_wdata | input | 8 | New offset |
| ofs_rdata | output | 8 | Current offset |
| dat_we | input | 1 | Write the selected register |
| dat_wdata | input | 32 | Write data |
| dat_rdata | output | 32 | Contents of the selected register |
| win_valid | output | NB | Per-bank window valid |
| win_base | output | NB*32 | Per-bank window base, bank n in bits 32n+31:32n |
| win_size | output | NB*32 | Per-bank window size in bytes, same packing |
| ecc_irq | output | 1 | ECC error interrupt |

## Verification
Two functions can act in the same cycle: loading a new offset and writing through the data port. The bench drives both strobes on the same edge, with the offset register pointing at refresh and the new offset pointing at timing. It then reads both registers back. The check passes only if refresh holds the masked write data and timing still holds its reset value. A second overlap is a configuration write that toggles bit 31 while a bank word is already set. For that case the bench checks the window valid flag and status bit 31 together, in the same cycle after the write.

// File: rtl/sdram_cfg_pkg.sv
// Shared constants for the SDRAM configuration register unit: register
// offsets, write masks and reset values. Assumes 32-bit registers and an
// 8-bit offset space.
package sdram_cfg_pkg;

    localparam int OFS_W  = 8;
    localparam int DATA_W = 32;

    localparam logic [OFS_W-1:0] OFF_ERRST0 = 8'h00;
    localparam logic [OFS_W-1:0] OFF_ERRST1 = 8'h08;
    localparam logic [OFS_W-1:0] OFF_ERRADR = 8'h10;
    localparam logic [OFS_W-1:0] OFF_CONFIG = 8'h20;
    localparam logic [OFS_W-1:0] OFF_STATUS = 8'h24;
    localparam logic [OFS_W-1:0] OFF_RFSH   = 8'h30;
    localparam logic [OFS_W-1:0] OFF_PWRMGT = 8'h34;
    localparam logic [OFS_W-1:0] OFF_BANK0  = 8'h40;
    localparam logic [OFS_W-1:0] OFF_TIMING = 8'h80;
    localparam logic [OFS_W-1:0] OFF_ECCCFG = 8'h94;
    localparam logic [OFS_W-1:0] OFF_ECCERR = 8'h98;

    localparam logic [DATA_W-1:0] MASK_BANK   = 32'hFFDE_E001;
    localparam logic [DATA_W-1:0] MASK_RFSH   = 32'h3FF8_0000;
    localparam logic [DATA_W-1:0] MASK_TIMING = 32'h018F_C01F;
    localparam logic [DATA_W-1:0] MASK_ECCCFG = 32'h00F0_0000;
    localparam logic [DATA_W-1:0] MASK_PWRKEEP = 32'hF800_0000;
    localparam logic [DATA_W-1:0] PWR_FORCED  = 32'h07C0_0000;

    localparam logic [DATA_W-1:0] RST_CONFIG = 32'h0080_0000;
    localparam logic [DATA_W-1:0] RST_RFSH   = 32'h05F0_0000;
    localparam logic [DATA_W-1:0] RST_TIMING = 32'h0085_4009;
    localparam logic [DATA_W-1:0] RST_PWRMGT = 32'h07C0_0000;

    // Bank word field positions used by the window decoder.
    localparam int BASE_LSB  = 23;
    localparam int SIZE_LSB  = 17;
    localparam int SIZE_W    = 3;
    localparam int VALID_BIT = 0;
    localparam int ENA_BIT   = 31;
    localparam int SREF_BIT  = 30;

    localparam logic [DATA_W-1:0] MIN_BANK_BYTES = 32'h0040_0000;

endpackage

// File: rtl/sdcfg_bank.sv
// One bank-configuration word and its window decoder. It stores the masked
// write data and presents base, size and a valid flag that is gated by the
// controller enable. It assumes the enable input comes from the global
// configuration register.
module sdcfg_bank
    import sdram_cfg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic              en_i,
    output logic [DATA_W-1:0] reg_o,
    output logic              win_valid_o,
    output logic [DATA_W-1:0] win_base_o,
    output logic [DATA_W-1:0] win_size_o
);

    logic [DATA_W-1:0] word_q;

    // Store the masked bank word.
    always_ff @(posedge clk) begin
        if (!rst_n)
            word_q <= '0;
        else if (we_i)
            word_q <= wdata_i & MASK_BANK;
    end

    // Decode the stored word into an address window.
    always_comb begin
        win_base_o  = {word_q[DATA_W-1:BASE_LSB], {BASE_LSB{1'b0}}};
        win_size_o  = MIN_BANK_BYTES << word_q[SIZE_LSB +: SIZE_W];
        win_valid_o = word_q[VALID_BIT] & en_i;
    end

    assign reg_o = word_q;

    assert_win_needs_enable_R4: assert property (@(posedge clk) disable iff (!rst_n)
        win_valid_o |-> en_i);

    assert_win_follows_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (we_i && en_i && wdata_i[VALID_BIT]) |=> (win_valid_o || !en_i));

endmodule

// File: rtl/sdcfg_enable.sv
// Global configuration word and the status word it drives. Status bit 31
// reports the controller as switched off, and status bit 30 follows the
// transitions of configuration bit 30. The status word cannot be written.
module sdcfg_enable
    import sdram_cfg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] cfg_o,
    output logic [DATA_W-1:0] sts_o
);

    logic [DATA_W-1:0] cfg_q;
    logic              sts_off_q;
    logic              sts_sref_q;

    // Hold the configuration word, all bits writable.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cfg_q <= RST_CONFIG;
        else if (we_i)
            cfg_q <= wdata_i;
    end

    // Update status bits on transitions of the enable and self-refresh bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sts_off_q  <= 1'b0;
            sts_sref_q <= 1'b0;
        end else if (we_i) begin
            if (!cfg_q[ENA_BIT] && wdata_i[ENA_BIT])
                sts_off_q <= 1'b0;
            else if (cfg_q[ENA_BIT] && !wdata_i[ENA_BIT])
                sts_off_q <= 1'b1;
            if (!cfg_q[SREF_BIT] && wdata_i[SREF_BIT])
                sts_sref_q <= 1'b1;
            else if (cfg_q[SREF_BIT] && !wdata_i[SREF_BIT])
                sts_sref_q <= 1'b0;
        end
    end

    assign cfg_o = cfg_q;
    assign sts_o = {sts_off_q, sts_sref_q, {(DATA_W-2){1'b0}}};

    assert_enable_rise_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cfg_q[ENA_BIT]) |-> !sts_o[ENA_BIT]);

    assert_enable_fall_sets_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cfg_q[ENA_BIT]) |-> sts_o[ENA_BIT]);

    assert_status_only_on_cfg_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sts_o) |-> !$stable(cfg_q[ENA_BIT:SREF_BIT]));

endmodule

// File: rtl/sdcfg_errlog.sv
// Error bookkeeping registers: two write-one-to-clear error status words,
// the error address and the ECC error status with its interrupt. It assumes
// that at most one write strobe is active per cycle.
module sdcfg_errlog
    import sdram_cfg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we_st0_i,
    input  logic              we_st1_i,
    input  logic              we_adr_i,
    input  logic              we_ecc_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] st0_o,
    output logic [DATA_W-1:0] st1_o,
    output logic [DATA_W-1:0] adr_o,
    output logic [DATA_W-1:0] ecc_o,
    output logic              irq_o
);

    logic [DATA_W-1:0] st0_q, st1_q, adr_q, ecc_q;
    logic              irq_q;

    // Clear error status bits that are written as ones.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st0_q <= '0;
            st1_q <= '0;
        end else begin
            if (we_st0_i)
                st0_q <= st0_q & ~wdata_i;
            if (we_st1_i)
                st1_q <= st1_q & ~wdata_i;
        end
    end

    // Store the error address and the ECC error status.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            adr_q <= '0;
            ecc_q <= '0;
        end else begin
            if (we_adr_i)
                adr_q <= wdata_i;
            if (we_ecc_i)
                ecc_q <= wdata_i;
        end
    end

    // Raise or lower the interrupt on zero crossings of the ECC status.
    always_ff @(posedge clk) begin
        if (!rst_n)
            irq_q <= 1'b0;
        else if (we_ecc_i)
            irq_q <= (wdata_i != '0);
    end

    assign st0_o = st0_q;
    assign st1_o = st1_q;
    assign adr_o = adr_q;
    assign ecc_o = ecc_q;
    assign irq_o = irq_q;

    assert_errst_never_sets_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ((st0_q & ~$past(st0_q)) == '0) && ((st1_q & ~$past(st1_q)) == '0));

    assert_irq_rise_needs_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_o) |-> $past(we_ecc_i));

    assert_irq_matches_status_R9: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o == (ecc_q != '0));

endmodule

// File: rtl/sdram_cfg_regs.sv
// Top of the SDRAM configuration register unit. It holds the offset register,
// the plain masked registers and the read multiplexer, and instantiates the
// enable/status logic, the error log and one decoder per bank. It assumes
// the bank count keeps bank offsets below the timing offset.
module sdram_cfg_regs
    import sdram_cfg_pkg::*;
#(
    parameter int NB = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 ofs_we,
    input  logic [OFS_W-1:0]     ofs_wdata,
    output logic [OFS_W-1:0]     ofs_rdata,
    input  logic                 dat_we,
    input  logic [DATA_W-1:0]    dat_wdata,
    output logic [DATA_W-1:0]    dat_rdata,
    output logic [NB-1:0]        win_valid,
    output logic [NB*DATA_W-1:0] win_base,
    output logic [NB*DATA_W-1:0] win_size,
    output logic                 ecc_irq
);

    localparam int BANK_STRIDE = 4;

    logic [OFS_W-1:0]  ofs_q;
    logic [DATA_W-1:0] rfsh_q, pwr_q, tim_q, eccfg_q;
    logic [DATA_W-1:0] cfg_w, sts_w, st0_w, st1_w, adr_w, ecc_w;
    logic [DATA_W-1:0] bank_w [NB];

    // Latch the register offset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ofs_q <= '0;
        else if (ofs_we)
            ofs_q <= ofs_wdata;
    end

    // Write the plain masked registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rfsh_q  <= RST_RFSH;
            pwr_q   <= RST_PWRMGT;
            tim_q   <= RST_TIMING;
            eccfg_q <= '0;
        end else if (dat_we) begin
            case (ofs_q)
                OFF_RFSH:   rfsh_q  <= dat_wdata & MASK_RFSH;
                OFF_PWRMGT: pwr_q   <= (dat_wdata & MASK_PWRKEEP) | PWR_FORCED;
                OFF_TIMING: tim_q   <= dat_wdata & MASK_TIMING;
                OFF_ECCCFG: eccfg_q <= dat_wdata & MASK_ECCCFG;
                default: ;
            endcase
        end
    end

    sdcfg_enable u_enable (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_i    (dat_we && (ofs_q == OFF_CONFIG)),
        .wdata_i (dat_wdata),
        .cfg_o   (cfg_w),
        .sts_o   (sts_w)
    );

    sdcfg_errlog u_errlog (
        .clk      (clk),
        .rst_n    (rst_n),
        .we_st0_i (dat_we && (ofs_q == OFF_ERRST0)),
        .we_st1_i (dat_we && (ofs_q == OFF_ERRST1)),
        .we_adr_i (dat_we && (ofs_q == OFF_ERRADR)),
        .we_ecc_i (dat_we && (ofs_q == OFF_ECCERR)),
        .wdata_i  (dat_wdata),
        .st0_o    (st0_w),
        .st1_o    (st1_w),
        .adr_o    (adr_w),
        .ecc_o    (ecc_w),
        .irq_o    (ecc_irq)
    );

    for (genvar gi = 0; gi < NB; gi++) begin : g_bank
        localparam logic [OFS_W-1:0] MY_OFS = OFF_BANK0 + OFS_W'(gi * BANK_STRIDE);
        sdcfg_bank u_bank (
            .clk         (clk),
            .rst_n       (rst_n),
            .we_i        (dat_we && (ofs_q == MY_OFS)),
            .wdata_i     (dat_wdata),
            .en_i        (cfg_w[ENA_BIT]),
            .reg_o       (bank_w[gi]),
            .win_valid_o (win_valid[gi]),
            .win_base_o  (win_base[gi*DATA_W +: DATA_W]),
            .win_size_o  (win_size[gi*DATA_W +: DATA_W])
        );
    end

    // Select the register named by the offset for the data port.
    always_comb begin
        dat_rdata = '0;
        case (ofs_q)
            OFF_ERRST0: dat_rdata = st0_w;
            OFF_ERRST1: dat_rdata = st1_w;
            OFF_ERRADR: dat_rdata = adr_w;
            OFF_CONFIG: dat_rdata = cfg_w;
            OFF_STATUS: dat_rdata = sts_w;
            OFF_RFSH:   dat_rdata = rfsh_q;
            OFF_PWRMGT: dat_rdata = pwr_q;
            OFF_TIMING: dat_rdata = tim_q;
            OFF_ECCCFG: dat_rdata = eccfg_q;
            OFF_ECCERR: dat_rdata = ecc_w;
            default: ;
        endcase
        for (int i = 0; i < NB; i++) begin
            if (ofs_q == OFF_BANK0 + OFS_W'(i * BANK_STRIDE))
                dat_rdata = bank_w[i];
        end
    end

    assign ofs_rdata = ofs_q;

    assert_rfsh_uses_old_offset_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (dat_we && ofs_q == OFF_RFSH) |=> (rfsh_q == ($past(dat_wdata) & MASK_RFSH)));

    assert_pwr_forced_R8: assert property (@(posedge clk) disable iff (!rst_n)
        dat_we |=> (pwr_q[26:22] == 5'h1F));

    assert_window_off_when_disabled_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_w[ENA_BIT] |-> (win_valid == '0));

endmodule

// File: tb/tb_sdram_cfg_regs.sv
module tb_sdram_cfg_regs;

    localparam int NB = 4;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             ofs_we = 1'b0;
    logic [7:0]       ofs_wdata = '0;
    logic [7:0]       ofs_rdata;
    logic             dat_we = 1'b0;
    logic [31:0]      dat_wdata = '0;
    logic [31:0]      dat_rdata;
    logic [NB-1:0]    win_valid;
    logic [NB*32-1:0] win_base;
    logic [NB*32-1:0] win_size;
    logic             ecc_irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    sdram_cfg_regs #(.NB(NB)) dut (
        .clk(clk), .rst_n(rst_n),
        .ofs_we(ofs_we), .ofs_wdata(ofs_wdata), .ofs_rdata(ofs_rdata),
        .dat_we(dat_we), .dat_wdata(dat_wdata), .dat_rdata(dat_rdata),
        .win_valid(win_valid), .win_base(win_base), .win_size(win_size),
        .ecc_irq(ecc_irq)
    );

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %08h expected %08h", tag, got, exp);
        end
    endtask

    task automatic set_ofs(input logic [7:0] o);
        @(negedge clk);
        ofs_we = 1'b1; ofs_wdata = o;
        @(negedge clk);
        ofs_we = 1'b0;
    endtask

    task automatic wreg(input logic [7:0] o, input logic [31:0] v);
        set_ofs(o);
        dat_we = 1'b1; dat_wdata = v;
        @(negedge clk);
        dat_we = 1'b0;
    endtask

    task automatic rreg(input logic [7:0] o, output logic [31:0] v);
        set_ofs(o);
        v = dat_rdata;
    endtask

    task automatic t_reset;
        logic [31:0] v;
        check("R1 offset", {24'h0, ofs_rdata}, 32'h0);
        check("R1 windows", {28'h0, win_valid}, 32'h0);
        check("R1 irq", {31'h0, ecc_irq}, 32'h0);
        rreg(8'h20, v); check("R1 config", v, 32'h0080_0000);
        rreg(8'h30, v); check("R1 refresh", v, 32'h05F0_0000);
        rreg(8'h80, v); check("R1 timing", v, 32'h0085_4009);
        rreg(8'h34, v); check("R1 pwrmgt", v, 32'h07C0_0000);
        rreg(8'h24, v); check("R1 status", v, 32'h0);
        rreg(8'h40, v); check("R1 bank0", v, 32'h0);
        rreg(8'h98, v); check("R1 eccerr", v, 32'h0);
    endtask

    task automatic t_same_cycle;
        logic [31:0] v;
        set_ofs(8'h30);
        @(negedge clk);
        ofs_we = 1'b1; ofs_wdata = 8'h80;
        dat_we = 1'b1; dat_wdata = 32'hFFFF_FFFF;
        @(negedge clk);
        ofs_we = 1'b0; dat_we = 1'b0;
        check("R2 new offset", {24'h0, ofs_rdata}, 32'h80);
        check("R2 timing untouched", dat_rdata, 32'h0085_4009);
        rreg(8'h30, v); check("R2 refresh got data", v, 32'h3FF8_0000);
    endtask

    task automatic t_bank_decode;
        logic [31:0] v;
        wreg(8'h40, 32'hFFFF_FFFF);
        rreg(8'h40, v); check("R3 bank0 mask", v, 32'hFFDE_E001);
        check("R3 bank0 base", win_base[31:0], 32'hFF80_0000);
        check("R3 bank0 size", win_size[31:0], 32'h2000_0000);
        check("R4 bank0 off while disabled", {31'h0, win_valid[0]}, 32'h0);
        wreg(8'h44, 32'h1002_0001);
        check("R3 bank1 base", win_base[63:32], 32'h1000_0000);
        check("R3 bank1 size", win_size[63:32], 32'h0080_0000);
        wreg(8'h4C, 32'h0000_0000);
        check("R3 bank3 size code 0", win_size[127:96], 32'h0040_0000);
    endtask

    task automatic t_enable;
        logic [31:0] v;
        wreg(8'h20, 32'h8000_0000);
        check("R4 windows on enable", {28'h0, win_valid}, 32'h3);
        rreg(8'h24, v); check("R5 status after rise", v, 32'h0);
        wreg(8'h20, 32'h0000_0000);
        check("R4 windows on disable", {28'h0, win_valid}, 32'h0);
        rreg(8'h24, v); check("R5 status after fall", v, 32'h8000_0000);
        wreg(8'h20, 32'h8000_0000);
        rreg(8'h24, v); check("R5 status after second rise", v, 32'h0);
        wreg(8'h20, 32'h0000_0000);
    endtask

    task automatic t_status;
        logic [31:0] v;
        wreg(8'h20, 32'h4000_0000);
        rreg(8'h24, v); check("R6 sref rise", v, 32'hC000_0000);
        wreg(8'h24, 32'h0000_0000);
        rreg(8'h24, v); check("R6 status write ignored", v, 32'hC000_0000);
        wreg(8'h20, 32'h0000_0000);
        rreg(8'h24, v); check("R6 sref fall", v, 32'h8000_0000);
    endtask

    task automatic t_errst;
        logic [31:0] v;
        wreg(8'h00, 32'hFFFF_FFFF);
        rreg(8'h00, v); check("R7 errst0 not set", v, 32'h0);
        wreg(8'h08, 32'hA5A5_A5A5);
        rreg(8'h08, v); check("R7 errst1 not set", v, 32'h0);
    endtask

    task automatic t_masks;
        logic [31:0] v;
        wreg(8'h80, 32'hFFFF_FFFF);
        rreg(8'h80, v); check("R8 timing mask", v, 32'h018F_C01F);
        wreg(8'h94, 32'hFFFF_FFFF);
        rreg(8'h94, v); check("R8 ecccfg mask", v, 32'h00F0_0000);
        wreg(8'h34, 32'hFFFF_FFFF);
        rreg(8'h34, v); check("R8 pwrmgt all ones", v, 32'hFFC0_0000);
        wreg(8'h34, 32'h0000_0000);
        rreg(8'h34, v); check("R8 pwrmgt forced", v, 32'h07C0_0000);
        wreg(8'h30, 32'h0000_0000);
        rreg(8'h30, v); check("R8 refresh zero", v, 32'h0);
    endtask

    task automatic t_ecc;
        logic [31:0] v;
        set_ofs(8'h98);
        @(negedge clk);
        dat_we = 1'b1; dat_wdata = 32'h0000_0005;
        @(negedge clk);
        dat_we = 1'b0;
        check("R9 irq rises", {31'h0, ecc_irq}, 32'h1);
        check("R11 eccerr stored", dat_rdata, 32'h0000_0005);
        wreg(8'h98, 32'h8000_0000);
        check("R9 irq stays", {31'h0, ecc_irq}, 32'h1);
        wreg(8'h98, 32'h0);
        check("R9 irq falls", {31'h0, ecc_irq}, 32'h0);
    endtask

    task automatic t_full_words;
        logic [31:0] v;
        wreg(8'h10, 32'h1234_5678);
        rreg(8'h10, v); check("R11 erraddr", v, 32'h1234_5678);
        wreg(8'h20, 32'h1234_5678);
        rreg(8'h20, v); check("R11 config", v, 32'h1234_5678);
        wreg(8'h20, 32'h0);
    endtask

    task automatic t_unimpl;
        logic [31:0] v;
        wreg(8'h0C, 32'hFFFF_FFFF);
        rreg(8'h0C, v); check("R10 unimpl reads zero", v, 32'h0);
        wreg(8'h50, 32'hFFFF_FFFF);
        rreg(8'h50, v); check("R10 past banks zero", v, 32'h0);
        rreg(8'h40, v); check("R10 bank0 untouched", v, 32'hFFDE_E001);
        rreg(8'h30, v); check("R10 refresh untouched", v, 32'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_same_cycle();
        t_bank_decode();
        t_enable();
        t_status();
        t_errst();
        t_masks();
        t_ecc();
        t_full_words();
        t_unimpl();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule